// File: doc/BRIEF.md
# Bus Cycle Breakpoint Comparator

This block is a two-channel hardware breakpoint that watches every bus cycle of the processor. It also watches cycles driven by another bus master once the processor has released the bus. Each channel holds the following settings:

- an address with a per-bit mask;
- a qualifier for cycle kind (fetch or data);
- a qualifier for direction (read or write);
- an operand-size qualifier.

Channel B can also require a data value, under a per-bit data mask, in the same cycle as the address. When a cycle satisfies a channel, the block does three things:

- it sets a sticky flag for that channel, with a separate flag for processor cycles and for external-master cycles;
- it pulses a break request for one cycle;
- it reports which program counter the exception logic should stack: the matching address, or the address of the next instruction.

The settings come in on static configuration ports. Software clears flags through a write strobe with a data word, in which a zero bit clears the flag at that position.

Top module: `bus_break_unit`

## Requirements
- R1: A `*_amask` bit of 1 removes that address bit from the compare. Every other bit of `bus_addr` must equal the channel's address setting.
- R2: On processor cycles the low address bits are ignored according to `bus_size`. For longword (2) bits 1..0 are ignored, and for word (1) bit 0 is ignored. For byte (0) every bit is compared. A `bus_size` of 3 is handled as longword.
- R3: The kind qualifier is 0=disabled, 1=fetch only, 2=data only, 3=either. The direction qualifier is 0=disabled, 1=read only, 2=write only, 3=either. A value of 0 in either one means the channel never matches.
- R4: The size qualifier is 0=any, 1=byte, 2=word, 3=longword. On a processor cycle with a nonzero qualifier, the channel matches only when the access size has that code.
- R5: When `b_den` is 1, channel B matches only if the address condition and the data condition both hold in the same cycle. A `b_dmask` bit of 1 removes that data bit from the compare.
- R6: Longword data compares all 32 bits. A word compares `b_data[15:0]` with `bus_data[31:16]` when `bus_addr[1]` is 1, and otherwise with `bus_data[15:0]`. A byte takes the lane `bus_data[8*k+7:8*k]` with k=`bus_addr[1:0]`. It compares that lane with `b_data[15:8]` when `bus_addr[0]` is 1, and otherwise with `b_data[7:0]`. For word and byte, `b_data[31:16]` and `b_dmask[31:16]` have no effect.
- R7: A cycle with `bus_ext`=1 can match only while `ext_brk_en` is 1. Such a cycle is always a data access and ignores the size qualifier. It compares address bits 26..0 in full and ignores bits 31..27. Its data is compared as a longword.
- R8: `brk_flags` bit 0 is set by channel A and bit 1 by channel B on processor cycles. Bit 2 is set by channel A and bit 3 by channel B on external-master cycles. Each flag is set on the clock edge that samples the matching cycle.
- R9: A flag stays set until `clr_we` is 1 with a 0 in that bit of `clr_wdata`. If a flag is set and cleared on the same edge, the set wins.
- R10: `brk_req` is 1 for exactly the one cycle after each matching bus cycle. After reset, `brk_req`, `brk_pc_next` and `brk_flags` are all 0.
- R11: With `brk_req`, `brk_pc_next` is 0 on a processor fetch cycle where a matching channel has its after-execution bit clear, which means the matching address is stacked. It is 1 in every other matching cycle. It is 0 whenever `brk_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data, lane-positioned |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword |
| bus_write | input | 1 | 1 write, 0 read |
| bus_fetch | input | 1 | 1 instruction fetch, 0 data access |
| bus_ext | input | 1 | Cycle driven by another bus master |
| ext_brk_en | input | 1 | Allows matches on external-master cycles |
| a_addr | input | 32 | Channel A address |
| a_amask | input | 32 | Channel A address mask |
| a_kind | input | 2 | Channel A kind qualifier |
| a_dir | input | 2 | Channel A direction qualifier |
| a_size | input | 2 | Channel A size qualifier |
| a_after | input | 1 | Channel A fetch break taken after execution |
| b_addr | input | 32 | Channel B address |
| b_amask | input | 32 | Channel B address mask |
| b_kind | input | 2 | Channel B kind qualifier |
| b_dir | input | 2 | Channel B direction qualifier |
| b_size | input | 2 | Channel B size qualifier |
| b_after | input | 1 | Channel B fetch break taken after execution |
| b_den | input | 1 | Channel B data condition enable |
| b_data | input | 32 | Channel B data value |
| b_dmask | input | 32 | Channel B data mask |
| clr_we | input | 1 | Flag clear strobe |
| clr_wdata | input | 4 | Zero bits clear the matching flags |
| brk_flags | output | 4 | Sticky match flags |
| brk_req | output | 1 | One-cycle break request |
| brk_pc_next | output | 1 | 1 stack next PC, 0 stack matching address |

## Verification
Every output of this block is registered one stage behind the bus cycle it judges. A wrong address care mask, a wrong lane choice or a wrong qualifier decode therefore shows at the ports one clock after the offending cycle. It appears as a missing or spurious `brk_req`, or as a flag bit in the wrong position. Flag state that is corrupted or not held shows the same way, and because the flags are sticky it remains visible on every later clock until a clear. The bench runs a behavioural model of every output, compares it on each clock over directed corner cycles and a long run of random cycles clustered around the programmed addresses, and adds directed checks on the lane, size and external-master boundaries.

// File: rtl/brk_pkg.sv
package brk_pkg;

   typedef enum logic [1:0] {
      KIND_OFF   = 2'd0,
      KIND_FETCH = 2'd1,
      KIND_DATA  = 2'd2,
      KIND_ANY   = 2'd3
   } kind_q_e;

   typedef enum logic [1:0] {
      DIR_OFF   = 2'd0,
      DIR_READ  = 2'd1,
      DIR_WRITE = 2'd2,
      DIR_ANY   = 2'd3
   } dir_q_e;

   typedef enum logic [1:0] {
      SZQ_ANY  = 2'd0,
      SZQ_BYTE = 2'd1,
      SZQ_WORD = 2'd2,
      SZQ_LONG = 2'd3
   } size_q_e;

   localparam logic [1:0] ACC_BYTE = 2'd0;
   localparam logic [1:0] ACC_WORD = 2'd1;
   localparam logic [1:0] ACC_LONG = 2'd2;

   typedef struct packed {
      kind_q_e kind;
      dir_q_e  dir;
      size_q_e size;
   } chan_qual_t;

endpackage

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp
   import brk_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int EXT_ADDR_W = 27
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [ADDR_W-1:0] ref_mask,
   input  logic [1:0]        acc_size,
   input  logic              ext,
   output logic              eq
);

   localparam logic [ADDR_W-1:0] EXT_KEEP =
      {{(ADDR_W-EXT_ADDR_W){1'b0}}, {EXT_ADDR_W{1'b1}}};

   logic [ADDR_W-1:0] care;

   always_comb begin
      care = ~ref_mask;
      if (ext) begin
         care = care & EXT_KEEP;
      end else if (acc_size == ACC_WORD) begin
         care[0] = 1'b0;
      end else if (acc_size != ACC_BYTE) begin
         care[1:0] = 2'b00;
      end
   end

   assign eq = (((bus_addr ^ ref_addr) & care) == '0);

endmodule

// File: rtl/brk_data_cmp.sv
module brk_data_cmp
   import brk_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] bus_data,
   input  logic [DATA_W-1:0] ref_data,
   input  logic [DATA_W-1:0] ref_mask,
   input  logic [1:0]        acc_size,
   input  logic [1:0]        lane,
   input  logic              full,
   output logic              eq
);

   localparam int HALF  = DATA_W / 2;
   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("brk_data_cmp: lane selection assumes a 32-bit data bus");
      end
   endgenerate

   logic [HALF-1:0] half_sel;
   logic [7:0]      byte_sel;
   logic [7:0]      byte_ref;
   logic [7:0]      byte_msk;

   always_comb begin
      half_sel = lane[1] ? bus_data[DATA_W-1:HALF] : bus_data[HALF-1:0];
      byte_sel = '0;
      for (int k = 0; k < LANES; k++) begin
         if (lane == k[1:0]) byte_sel = bus_data[8*k +: 8];
      end
      byte_ref = lane[0] ? ref_data[15:8] : ref_data[7:0];
      byte_msk = lane[0] ? ref_mask[15:8] : ref_mask[7:0];
   end

   always_comb begin
      if (full || (acc_size != ACC_BYTE && acc_size != ACC_WORD))
         eq = (((bus_data ^ ref_data) & ~ref_mask) == '0);
      else if (acc_size == ACC_WORD)
         eq = (((half_sel ^ ref_data[HALF-1:0]) & ~ref_mask[HALF-1:0]) == '0);
      else
         eq = (((byte_sel ^ byte_ref) & ~byte_msk) == '0);
   end

endmodule

// File: rtl/brk_chan.sv
module brk_chan
   import brk_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int EXT_ADDR_W = 27,
   parameter int DATA_W     = 32
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        size,
   input  logic              write,
   input  logic              fetch,
   input  logic              ext,
   input  logic              ext_en,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [ADDR_W-1:0] ref_amask,
   input  chan_qual_t        qual,
   input  logic              data_en,
   input  logic [DATA_W-1:0] ref_data,
   input  logic [DATA_W-1:0] ref_dmask,
   output logic              hit_cpu,
   output logic              hit_ext
);

   logic [1:0] eff_size;
   logic       is_fetch;
   logic       kind_ok, dir_ok, size_ok;
   logic       addr_eq, data_eq, base;

   assign eff_size = (size == 2'd3) ? ACC_LONG : size;
   assign is_fetch = fetch & ~ext;

   always_comb begin
      unique case (qual.kind)
         KIND_FETCH: kind_ok = is_fetch;
         KIND_DATA:  kind_ok = ~is_fetch;
         KIND_ANY:   kind_ok = 1'b1;
         default:    kind_ok = 1'b0;
      endcase
      unique case (qual.dir)
         DIR_READ:  dir_ok = ~write;
         DIR_WRITE: dir_ok = write;
         DIR_ANY:   dir_ok = 1'b1;
         default:   dir_ok = 1'b0;
      endcase
      size_ok = ext || (qual.size == SZQ_ANY) || (qual.size == size_q_e'(eff_size + 2'd1));
   end

   brk_addr_cmp #(.ADDR_W(ADDR_W), .EXT_ADDR_W(EXT_ADDR_W)) u_acmp (
      .bus_addr (addr),
      .ref_addr (ref_addr),
      .ref_mask (ref_amask),
      .acc_size (eff_size),
      .ext      (ext),
      .eq       (addr_eq)
   );

   brk_data_cmp #(.DATA_W(DATA_W)) u_dcmp (
      .bus_data (data),
      .ref_data (ref_data),
      .ref_mask (ref_dmask),
      .acc_size (eff_size),
      .lane     (addr[1:0]),
      .full     (ext),
      .eq       (data_eq)
   );

   assign base    = valid & kind_ok & dir_ok & size_ok & addr_eq & (~data_en | data_eq);
   assign hit_cpu = base & ~ext;
   assign hit_ext = base & ext & ext_en;

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
   import brk_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int EXT_ADDR_W = 27,
   parameter int DATA_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [1:0]        bus_size,
   input  logic              bus_write,
   input  logic              bus_fetch,
   input  logic              bus_ext,
   input  logic              ext_brk_en,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [ADDR_W-1:0] a_amask,
   input  logic [1:0]        a_kind,
   input  logic [1:0]        a_dir,
   input  logic [1:0]        a_size,
   input  logic              a_after,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [ADDR_W-1:0] b_amask,
   input  logic [1:0]        b_kind,
   input  logic [1:0]        b_dir,
   input  logic [1:0]        b_size,
   input  logic              b_after,
   input  logic              b_den,
   input  logic [DATA_W-1:0] b_data,
   input  logic [DATA_W-1:0] b_dmask,
   input  logic              clr_we,
   input  logic [3:0]        clr_wdata,
   output logic [3:0]        brk_flags,
   output logic              brk_req,
   output logic              brk_pc_next
);

   localparam int NUM_CH = 2;
   localparam int FLAG_W = 2 * NUM_CH;

   generate
      if (EXT_ADDR_W < 2 || EXT_ADDR_W >= ADDR_W) begin : g_bad_ext
         $error("bus_break_unit: external address width must be in [2, ADDR_W)");
      end
   endgenerate

   logic [NUM_CH-1:0] hit_cpu, hit_ext, hit_any, after_v;
   logic [FLAG_W-1:0] flags_q, flags_set;
   logic              brk_q, pcn_q, pcn_d, fetch_cpu;

   assign after_v = {b_after, a_after};

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      chan_qual_t        q;
      logic [ADDR_W-1:0] ra, rm;
      logic [DATA_W-1:0] rd, rdm;
      logic              den;
      if (c == 1) begin : g_with_data
         assign q   = '{kind: kind_q_e'(b_kind), dir: dir_q_e'(b_dir), size: size_q_e'(b_size)};
         assign ra  = b_addr;
         assign rm  = b_amask;
         assign den = b_den;
         assign rd  = b_data;
         assign rdm = b_dmask;
      end else begin : g_addr_only
         assign q   = '{kind: kind_q_e'(a_kind), dir: dir_q_e'(a_dir), size: size_q_e'(a_size)};
         assign ra  = a_addr;
         assign rm  = a_amask;
         assign den = 1'b0;
         assign rd  = '0;
         assign rdm = '0;
      end
      brk_chan #(.ADDR_W(ADDR_W), .EXT_ADDR_W(EXT_ADDR_W), .DATA_W(DATA_W)) u_chan (
         .valid     (bus_valid),
         .addr      (bus_addr),
         .data      (bus_data),
         .size      (bus_size),
         .write     (bus_write),
         .fetch     (bus_fetch),
         .ext       (bus_ext),
         .ext_en    (ext_brk_en),
         .ref_addr  (ra),
         .ref_amask (rm),
         .qual      (q),
         .data_en   (den),
         .ref_data  (rd),
         .ref_dmask (rdm),
         .hit_cpu   (hit_cpu[c]),
         .hit_ext   (hit_ext[c])
      );
   end

   assign hit_any   = hit_cpu | hit_ext;
   assign flags_set = {hit_ext, hit_cpu};
   assign fetch_cpu = bus_fetch & ~bus_ext;
   assign pcn_d     = (|hit_any) & ~(fetch_cpu & (|(hit_any & ~after_v)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         brk_q   <= 1'b0;
         pcn_q   <= 1'b0;
      end else begin
         flags_q <= (clr_we ? (flags_q & clr_wdata) : flags_q) | flags_set;
         brk_q   <= |hit_any;
         pcn_q   <= pcn_d;
      end
   end

   assign brk_flags   = flags_q;
   assign brk_req     = brk_q;
   assign brk_pc_next = pcn_q;

   assert_idle_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !brk_req);

   assert_req_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> (brk_flags != '0));

   assert_ext_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_ext && !ext_brk_en) |=> !brk_req);

   assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((brk_flags & $past(brk_flags)) == $past(brk_flags)));

   assert_ext_spares_cpu_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ext && !clr_we) |=> (brk_flags[1:0] == $past(brk_flags[1:0])));

   assert_pc_only_with_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !brk_req |-> !brk_pc_next);

endmodule

// File: tb/tb_bus_break_unit.sv
`timescale 1ns/1ps
module tb_bus_break_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 0, bus_write = 0, bus_fetch = 0, bus_ext = 0, ext_brk_en = 0;
   logic [31:0] bus_addr = 0, bus_data = 0;
   logic [1:0]  bus_size = 0;
   logic [31:0] a_addr = 0, a_amask = 0, b_addr = 0, b_amask = 0, b_data = 0, b_dmask = 0;
   logic [1:0]  a_kind = 0, a_dir = 0, a_size = 0, b_kind = 0, b_dir = 0, b_size = 0;
   logic        a_after = 0, b_after = 0, b_den = 0, clr_we = 0;
   logic [3:0]  clr_wdata = 0;
   logic [3:0]  brk_flags;
   logic        brk_req, brk_pc_next;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   bus_break_unit dut (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Behavioural model of one channel's decision for the current bus cycle
   function automatic bit ref_hit(input int ch);
      logic [31:0] ra, rm;
      logic [1:0]  kd, dr, sq;
      int          acc;
      bit          is_fetch;
      ra = (ch == 0) ? a_addr  : b_addr;
      rm = (ch == 0) ? a_amask : b_amask;
      kd = (ch == 0) ? a_kind  : b_kind;
      dr = (ch == 0) ? a_dir   : b_dir;
      sq = (ch == 0) ? a_size  : b_size;
      acc = (bus_size == 3) ? 2 : int'(bus_size);
      if (!bus_valid) return 0;
      if (bus_ext && !ext_brk_en) return 0;
      is_fetch = bus_fetch && !bus_ext;
      if (kd == 0 || (kd == 1 && !is_fetch) || (kd == 2 && is_fetch)) return 0;
      if (dr == 0 || (dr == 1 && bus_write) || (dr == 2 && !bus_write)) return 0;
      if (!bus_ext && sq != 0 && int'(sq) != acc + 1) return 0;
      for (int i = 0; i < 32; i++) begin
         if (rm[i]) continue;
         if (bus_ext && i >= 27) continue;
         if (!bus_ext && acc == 2 && i < 2) continue;
         if (!bus_ext && acc == 1 && i < 1) continue;
         if (bus_addr[i] != ra[i]) return 0;
      end
      if (ch == 1 && b_den) begin
         if (bus_ext || acc == 2) begin
            if (((bus_data ^ b_data) & ~b_dmask) != 0) return 0;
         end else if (acc == 1) begin
            logic [15:0] w;
            w = bus_addr[1] ? bus_data[31:16] : bus_data[15:0];
            if (((w ^ b_data[15:0]) & ~b_dmask[15:0]) != 0) return 0;
         end else begin
            logic [7:0] bv, rv, mv;
            bv = 8'(bus_data >> (8 * int'(bus_addr[1:0])));
            rv = bus_addr[0] ? b_data[15:8]  : b_data[7:0];
            mv = bus_addr[0] ? b_dmask[15:8] : b_dmask[7:0];
            if (((bv ^ rv) & ~mv) != 0) return 0;
         end
      end
      return 1;
   endfunction

   logic [3:0] m_flags = 0;
   logic       m_brk = 0, m_pc = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flags = 0; m_brk = 0; m_pc = 0;
      end else begin
         bit ha, hb, bf;
         ha = ref_hit(0);
         hb = ref_hit(1);
         if (clr_we) m_flags = m_flags & clr_wdata;
         if (ha) m_flags[bus_ext ? 2 : 0] = 1'b1;
         if (hb) m_flags[bus_ext ? 3 : 1] = 1'b1;
         m_brk = ha | hb;
         bf = bus_fetch && !bus_ext && ((ha && !a_after) || (hb && !b_after));
         m_pc = m_brk && !bf;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check("R10 model brk_req", 32'(brk_req), 32'(m_brk));
         check("R8 model flags", 32'(brk_flags), 32'(m_flags));
         check("R11 model pc select", 32'(brk_pc_next), 32'(m_pc));
      end
   end

   task automatic cyc(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                      input logic wr, input logic fe, input logic ex,
                      input logic ce = 0, input logic [3:0] cv = 4'hF);
      @(posedge clk); #1;
      bus_valid = 1; bus_addr = a; bus_data = d; bus_size = sz;
      bus_write = wr; bus_fetch = fe; bus_ext = ex; clr_we = ce; clr_wdata = cv;
      @(posedge clk); #1;
      bus_valid = 0; clr_we = 0;
      @(negedge clk);
   endtask

   task automatic clr(input logic [3:0] cv);
      @(posedge clk); #1; clr_we = 1; clr_wdata = cv;
      @(posedge clk); #1; clr_we = 0;
      @(negedge clk);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      check("R10 reset flags", 32'(brk_flags), 0);
      check("R10 reset brk_req", 32'(brk_req), 0);
      check("R11 reset pc select", 32'(brk_pc_next), 0);

      a_addr = 32'h1000_0040; a_kind = 3; a_dir = 3; a_size = 0; a_after = 0;
      cyc(32'h1000_0043, 0, 2, 0, 0, 0);
      check("R2 long ignores bits 1..0", 32'(brk_req), 1);
      check("R8 cpu flag A", 32'(brk_flags), 1);
      clr(4'h0);
      check("R9 clear all", 32'(brk_flags), 0);
      cyc(32'h1000_0043, 0, 0, 0, 0, 0);
      check("R2 byte compares all bits", 32'(brk_req), 0);
      cyc(32'h1000_0041, 0, 1, 0, 0, 0);
      check("R2 word ignores bit 0", 32'(brk_req), 1);
      cyc(32'h1000_0042, 0, 1, 0, 0, 0);
      check("R2 word compares bit 1", 32'(brk_req), 0);

      a_amask = 32'h0000_FF00;
      cyc(32'h1000_5540, 0, 2, 0, 0, 0);
      check("R1 masked bits ignored", 32'(brk_req), 1);
      cyc(32'h1001_0040, 0, 2, 0, 0, 0);
      check("R1 unmasked bit compared", 32'(brk_req), 0);
      a_amask = 0;

      a_kind = 1;
      cyc(32'h1000_0040, 0, 2, 0, 0, 0);
      check("R3 fetch-only rejects data", 32'(brk_req), 0);
      cyc(32'h1000_0040, 0, 2, 0, 1, 0);
      check("R3 fetch-only accepts fetch", 32'(brk_req), 1);
      a_dir = 2;
      cyc(32'h1000_0040, 0, 2, 0, 1, 0);
      check("R3 write-only rejects read", 32'(brk_req), 0);
      cyc(32'h1000_0040, 0, 2, 1, 1, 0);
      check("R3 write-only accepts write", 32'(brk_req), 1);
      a_kind = 0;
      cyc(32'h1000_0040, 0, 2, 1, 1, 0);
      check("R3 kind disabled", 32'(brk_req), 0);
      a_kind = 3; a_dir = 3;

      a_size = 2;
      cyc(32'h1000_0040, 0, 2, 0, 0, 0);
      check("R4 word qualifier rejects longword", 32'(brk_req), 0);
      cyc(32'h1000_0040, 0, 1, 0, 0, 0);
      check("R4 word qualifier accepts word", 32'(brk_req), 1);
      a_size = 0; a_kind = 0;
      clr(4'h0);

      b_addr = 32'h2000_0000; b_amask = 0; b_kind = 3; b_dir = 3; b_size = 0;
      b_den = 1; b_data = 32'hCAFE_1234; b_dmask = 0;
      cyc(32'h2000_0000, 32'hCAFE_1234, 2, 1, 0, 0);
      check("R5 address and data match", 32'(brk_req), 1);
      check("R8 cpu flag B", 32'(brk_flags), 2);
      cyc(32'h2000_0000, 32'hCAFE_1235, 2, 1, 0, 0);
      check("R5 data mismatch blocks", 32'(brk_req), 0);
      b_dmask = 32'h0000_000F;
      cyc(32'h2000_0000, 32'hCAFE_1235, 2, 1, 0, 0);
      check("R5 data mask ignores bits", 32'(brk_req), 1);
      cyc(32'h2000_0010, 32'hCAFE_1234, 2, 1, 0, 0);
      check("R5 address mismatch blocks", 32'(brk_req), 0);
      b_dmask = 0;

      b_amask = 32'h3; b_data = 32'hFFFF_BEEF;
      cyc(32'h2000_0002, 32'hBEEF_0000, 1, 0, 0, 0);
      check("R6 word upper lane, bits 31..16 ignored", 32'(brk_req), 1);
      cyc(32'h2000_0000, 32'hBEEF_0000, 1, 0, 0, 0);
      check("R6 word lower lane", 32'(brk_req), 0);
      b_data = 32'h0000_A55A;
      cyc(32'h2000_0001, 32'h0000_A500, 0, 0, 0, 0);
      check("R6 byte odd uses bits 15..8", 32'(brk_req), 1);
      cyc(32'h2000_0000, 32'h0000_005A, 0, 0, 0, 0);
      check("R6 byte even uses bits 7..0", 32'(brk_req), 1);
      cyc(32'h2000_0000, 32'h0000_00A5, 0, 0, 0, 0);
      check("R6 byte even wrong value", 32'(brk_req), 0);
      cyc(32'h2000_0003, 32'hA500_0000, 0, 0, 0, 0);
      check("R6 byte lane 3", 32'(brk_req), 1);
      cyc(32'h2000_0002, 32'h005A_0000, 0, 0, 0, 0);
      check("R6 byte lane 2", 32'(brk_req), 1);
      b_kind = 0; b_den = 0;
      clr(4'h0);

      a_addr = 32'hF800_0040; a_kind = 1; ext_brk_en = 1;
      cyc(32'h0000_0040, 0, 2, 0, 1, 1);
      check("R7 external is never a fetch", 32'(brk_req), 0);
      a_kind = 3;
      cyc(32'h0000_0040, 0, 2, 0, 1, 1);
      check("R7 external ignores bits 31..27", 32'(brk_req), 1);
      check("R8 external flag A", 32'(brk_flags), 4);
      a_size = 1;
      cyc(32'h0000_0040, 0, 2, 0, 0, 1);
      check("R7 external ignores size qualifier", 32'(brk_req), 1);
      cyc(32'h0000_0041, 0, 2, 0, 0, 1);
      check("R7 external compares bits 1..0", 32'(brk_req), 0);
      ext_brk_en = 0;
      cyc(32'h0000_0040, 0, 2, 0, 0, 1);
      check("R7 external disabled", 32'(brk_req), 0);
      cyc(32'hF800_0040, 0, 0, 0, 0, 0);
      check("R8 cpu and external flags", 32'(brk_flags), 5);
      repeat (3) @(negedge clk);
      check("R9 flags held while idle", 32'(brk_flags), 5);
      clr(4'b1110);
      check("R9 zero bit clears only its flag", 32'(brk_flags), 4);
      cyc(32'hF800_0040, 0, 0, 0, 0, 0, 1, 4'h0);
      check("R9 set wins over clear", 32'(brk_flags), 1);
      a_size = 0;

      a_addr = 32'h3000_0000; a_amask = 0; a_after = 0;
      b_addr = 32'h3000_0000; b_amask = 0; b_kind = 3; b_dir = 3; b_size = 0; b_after = 1;
      clr(4'h0);
      cyc(32'h3000_0000, 0, 2, 0, 1, 0);
      check("R11 before-execution fetch stacks match", 32'(brk_pc_next), 0);
      a_kind = 0;
      cyc(32'h3000_0000, 0, 2, 0, 1, 0);
      check("R11 after-execution fetch stacks next", 32'(brk_pc_next), 1);
      cyc(32'h3000_0000, 0, 2, 0, 0, 0);
      check("R11 data break stacks next", 32'(brk_pc_next), 1);
      @(negedge clk);
      check("R10 request lasts one cycle", 32'(brk_req), 0);

      for (int n = 0; n < 4000; n++) begin
         @(posedge clk); #1;
         if (n % 64 == 0) begin
            a_addr  = $urandom & 32'hF800_FFFC;
            b_addr  = $urandom & 32'hF800_FFFC;
            a_amask = ($urandom % 4 == 0) ? ($urandom & 32'h0000_0F0F) : 0;
            b_amask = ($urandom % 4 == 0) ? ($urandom & 32'h0000_0F0F) : 0;
            a_kind = 2'($urandom); a_dir = 2'($urandom); a_size = 2'($urandom);
            b_kind = 2'($urandom); b_dir = 2'($urandom); b_size = 2'($urandom);
            a_after = 1'($urandom); b_after = 1'($urandom); b_den = 1'($urandom);
            b_data = $urandom; b_dmask = ($urandom % 2) ? ($urandom & 32'h00FF_00FF) : 0;
            ext_brk_en = 1'($urandom);
         end
         bus_valid = ($urandom % 4 != 0);
         bus_addr  = (($urandom % 2) ? a_addr : b_addr) ^ ($urandom & 32'h0000_0003)
                     ^ (($urandom % 8 == 0) ? 32'h0000_0100 : 0)
                     ^ (($urandom % 8 == 0) ? 32'h0800_0000 : 0);
         bus_data  = ($urandom % 3 == 0) ? $urandom : (b_data ^ (($urandom % 2) ? 32'h0001_0000 : 0));
         bus_size  = 2'($urandom % 3);
         bus_write = 1'($urandom);
         bus_fetch = 1'($urandom);
         bus_ext   = ($urandom % 4 == 0);
         clr_we    = ($urandom % 16 == 0);
         clr_wdata = 4'($urandom);
      end
      @(posedge clk); #1; bus_valid = 0; clr_we = 0;
      repeat (2) @(negedge clk);
      summary();
   end

endmodule